// File: doc/BRIEF.md
# Character-Grid Display Timing Generator

This block turns a dot clock and the two flyback pulses of a monitor into the coordinates of an on-screen character grid. The grid has 10 rows of 24 character cells. Each cell is 10 dots wide and 16 glyph lines tall, and adjacent cells touch with no gap. For every dot clock the block reports the grid row and column, the glyph line and dot index that a glyph ROM would use, and whether the dot lies inside the grid at all. A downstream glyph lookup and colour stage uses these outputs to paint the screen.

The grid position is programmable for centring. A horizontal start value counts dot clocks after the horizontal flyback, and a vertical start value counts scan lines after the vertical flyback. The height of a character row is programmable from 16 to 63 scan lines. The 16 glyph lines are stretched over that height with an incremental remainder scaler, so no divider is needed. Double-width mode holds each glyph dot for two clocks. Double-height mode doubles the row height.

Top module: `chargrid_timing`

## Requirements
- R1: After reset, `disp_active` is low and `grid_row`, `grid_col`, `glyph_line` and `glyph_dot` read zero.
- R2: A clock edge that samples `hflb_n` low, where the previous edge sampled it high, restarts the dot count. `disp_active` can first be high after edge number `cfg_hstart`+1 following that edge, and at that point column 0 and dot 0 are shown.
- R3: In normal width, the dot index advances by one on every clock from 0 to 9. The column advances when the dot index wraps, from 0 to 23. The horizontal window spans 240 clocks.
- R4: With `cfg_dbl_width` = 1, each dot index is held for two clocks, and the horizontal window spans 480 clocks.
- R5: Each detected `hflb_n` fall is one scan line, and a detected `vflb_n` fall restarts the line count. Row 0 begins on fall number `cfg_vstart`+1 after the vertical restart. The vertical window lasts 10 rows of H scan lines each.
- R6: Within a row, the glyph line for scan line s is floor(16·s/H). H is the effective row height.
- R7: A `cfg_row_lines` value below 16 behaves as 16.
- R8: With `cfg_dbl_height` = 1, H is twice the programmed (clamped) row height.
- R9: A flyback input held low for many clocks counts as one fall only.
- R10: While `disp_active` is low, `grid_row`, `grid_col`, `glyph_line` and `glyph_dot` read zero.
- R11: A detected `hflb_n` fall during the window drops `disp_active` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hflb_n | input | 1 | Horizontal flyback, active low, synchronous to clk |
| vflb_n | input | 1 | Vertical flyback, active low, synchronous to clk |
| cfg_hstart | input | 8 | Dot clocks from horizontal restart to the first column |
| cfg_vstart | input | 8 | Scan lines from vertical restart to the first row |
| cfg_row_lines | input | 6 | Scan lines per character row (16 to 63) |
| cfg_dbl_height | input | 1 | Double the row height |
| cfg_dbl_width | input | 1 | Hold each glyph dot for two clocks |
| grid_row | output | 4 | Current grid row, 0 to 9 |
| grid_col | output | 5 | Current grid column, 0 to 23 |
| glyph_line | output | 4 | Glyph line index, 0 to 15 |
| glyph_dot | output | 4 | Glyph dot index, 0 to 9 |
| disp_active | output | 1 | Current dot lies inside the grid |

## Verification
A faulty horizontal counter shows up within one scan line as a column or dot value that is wrong at a known clock offset from the flyback edge. It can also show up as a window edge that is one clock early or late. A faulty remainder scaler or row counter stays hidden until the scan line where the floor crosses an integer. For that reason, rows are sampled at the last scan line of a row, at odd heights, and at the end of the frame, where a single-count error changes the glyph line or row at once. Counting a held-low flyback more than once shifts every later line, so it is checked on the line after the held pulse.

// File: rtl/cgt_pkg.sv
// Shared grid geometry and coordinate types for the character-grid timing generator.
package cgt_pkg;
    localparam int GLYPH_W       = 10;
    localparam int GLYPH_H       = 16;
    localparam int GRID_COLS     = 24;
    localparam int GRID_ROWS     = 10;
    localparam int MIN_ROW_LINES = 16;

    localparam int DOT_W  = $clog2(GLYPH_W);
    localparam int COL_W  = $clog2(GRID_COLS);
    localparam int ROW_W  = $clog2(GRID_ROWS);
    localparam int LINE_W = $clog2(GLYPH_H);

    typedef logic [DOT_W-1:0]  dot_t;
    typedef logic [COL_W-1:0]  col_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [LINE_W-1:0] gline_t;
endpackage

// File: rtl/cgt_fall_detect.sv
// Falling-edge detector for an active-low flyback input.
// Assumes the input is already synchronous to clk. It pulses for one
// cycle when the input is low and the previous sample was high, so a
// held-low input yields a single pulse.
module cgt_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_n,
    output logic fall
);
    logic prev_q;

    // Remember last sample; reset to the idle (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pulse_n;
    end

    assign fall = prev_q & ~pulse_n;
endmodule

// File: rtl/cgt_hscan.sv
// Horizontal scan: counts dot clocks since the last line restart, opens
// the 24-column window after the programmed start and walks dot and
// column indices, optionally holding each dot for two clocks.
// Assumes cfg values are stable within a line.
module cgt_hscan
    import cgt_pkg::*;
#(
    parameter int HSTART_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic [HSTART_W-1:0] hstart,
    input  logic                dbl_w,
    output logic                active,
    output col_t                col,
    output dot_t                dot
);
    localparam int HCNT_W = HSTART_W + 1;

    logic [HCNT_W-1:0] hcount;
    logic              half_q;
    logic              start_hit;
    logic              step;

    // Saturating clock count since the line restart; parked at max after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hcount <= '1;
        else if (line_start)         hcount <= '0;
        else if (hcount != '1)       hcount <= hcount + HCNT_W'(1);
    end

    assign start_hit = (hcount == {1'b0, hstart});
    assign step      = active && (!dbl_w || half_q);

    // Window state and dot/column walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            col    <= '0;
            dot    <= '0;
            half_q <= 1'b0;
        end else if (line_start) begin
            active <= 1'b0;
            col    <= '0;
            dot    <= '0;
            half_q <= 1'b0;
        end else if (!active && start_hit) begin
            active <= 1'b1;
            col    <= '0;
            dot    <= '0;
            half_q <= 1'b0;
        end else if (active) begin
            half_q <= dbl_w ? ~half_q : 1'b0;
            if (step) begin
                if (dot == DOT_W'(GLYPH_W - 1)) begin
                    dot <= '0;
                    if (col == COL_W'(GRID_COLS - 1)) active <= 1'b0;
                    else                              col    <= col + COL_W'(1);
                end else begin
                    dot <= dot + DOT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cgt_vscan.sv
// Vertical scan: counts scan lines since the frame restart, opens the
// 10-row window after the programmed start and derives the glyph line as
// floor(16*s/H) with a running remainder instead of a divider.
// Assumes H >= 16, so at most one glyph line step per scan line.
module cgt_vscan
    import cgt_pkg::*;
#(
    parameter int VSTART_W = 8,
    parameter int HEIGHT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic [VSTART_W-1:0] vstart,
    input  logic [HEIGHT_W-1:0] row_lines,
    input  logic                dbl_h,
    output logic                active,
    output row_t                row,
    output gline_t              gline
);
    localparam int VCNT_W = VSTART_W + 1;
    localparam int EH_W   = HEIGHT_W + 1;

    logic [VCNT_W-1:0] vcount;
    logic [HEIGHT_W-1:0] base_h;
    logic [EH_W-1:0]   eff_h;
    logic [EH_W-1:0]   sline;
    logic [EH_W:0]     rem;
    logic [EH_W:0]     rem_sum;
    logic              rem_wrap;
    logic              row_end;

    // Effective row height: clamp to the minimum, then optionally double.
    always_comb begin
        base_h = (row_lines < HEIGHT_W'(MIN_ROW_LINES)) ? HEIGHT_W'(MIN_ROW_LINES) : row_lines;
        eff_h  = dbl_h ? {base_h, 1'b0} : {1'b0, base_h};
    end

    assign rem_sum  = rem + (EH_W+1)'(GLYPH_H);
    assign rem_wrap = (rem_sum >= {1'b0, eff_h});
    assign row_end  = (sline == eff_h - EH_W'(1));

    // Saturating scan-line count since the frame restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                            vcount <= '1;
        else if (frame_start)                  vcount <= '0;
        else if (line_start && vcount != '1)   vcount <= vcount + VCNT_W'(1);
    end

    // Window state, row counter and glyph-line scaler, stepped per scan line.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            active <= 1'b0;
            row    <= '0;
            sline  <= '0;
            rem    <= '0;
            gline  <= '0;
        end else if (line_start) begin
            if (!active) begin
                if (vcount == {1'b0, vstart}) begin
                    active <= 1'b1;
                    row    <= '0;
                    sline  <= '0;
                    rem    <= '0;
                    gline  <= '0;
                end
            end else if (row_end) begin
                sline <= '0;
                rem   <= '0;
                gline <= '0;
                if (row == ROW_W'(GRID_ROWS - 1)) active <= 1'b0;
                else                               row    <= row + ROW_W'(1);
            end else begin
                sline <= sline + EH_W'(1);
                if (rem_wrap) begin
                    rem   <= rem_sum - {1'b0, eff_h};
                    gline <= gline + LINE_W'(1);
                end else begin
                    rem   <= rem_sum;
                end
            end
        end
    end
endmodule

// File: rtl/chargrid_timing.sv
// Character-grid display timing generator top.
// Detects flyback falls, runs the horizontal and vertical scans, and
// presents grid coordinates that read zero outside the grid window.
// Assumes flyback inputs are synchronous to the dot clock.
module chargrid_timing
    import cgt_pkg::*;
#(
    parameter int HSTART_W = 8,
    parameter int VSTART_W = 8,
    parameter int HEIGHT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hflb_n,
    input  logic                vflb_n,
    input  logic [HSTART_W-1:0] cfg_hstart,
    input  logic [VSTART_W-1:0] cfg_vstart,
    input  logic [HEIGHT_W-1:0] cfg_row_lines,
    input  logic                cfg_dbl_height,
    input  logic                cfg_dbl_width,
    output logic [ROW_W-1:0]    grid_row,
    output logic [COL_W-1:0]    grid_col,
    output logic [LINE_W-1:0]   glyph_line,
    output logic [DOT_W-1:0]    glyph_dot,
    output logic                disp_active
);
    localparam int NFLB = 2;

    logic [NFLB-1:0] flb_n;
    logic [NFLB-1:0] flb_fall;
    logic            h_act;
    logic            v_act;
    col_t            h_col;
    dot_t            h_dot;
    row_t            v_row;
    gline_t          v_line;

    assign flb_n = {vflb_n, hflb_n};

    // One falling-edge detector per flyback input (0: horizontal, 1: vertical).
    for (genvar gi = 0; gi < NFLB; gi++) begin : g_flb
        cgt_fall_detect u_fall (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse_n (flb_n[gi]),
            .fall    (flb_fall[gi])
        );
    end

    cgt_hscan #(.HSTART_W(HSTART_W)) u_hscan (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (flb_fall[0]),
        .hstart     (cfg_hstart),
        .dbl_w      (cfg_dbl_width),
        .active     (h_act),
        .col        (h_col),
        .dot        (h_dot)
    );

    cgt_vscan #(.VSTART_W(VSTART_W), .HEIGHT_W(HEIGHT_W)) u_vscan (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (flb_fall[1]),
        .line_start  (flb_fall[0]),
        .vstart      (cfg_vstart),
        .row_lines   (cfg_row_lines),
        .dbl_h       (cfg_dbl_height),
        .active      (v_act),
        .row         (v_row),
        .gline       (v_line)
    );

    // Output stage: coordinates are forced to zero outside the window.
    always_comb begin
        disp_active = h_act & v_act;
        grid_row    = disp_active ? v_row  : '0;
        grid_col    = disp_active ? h_col  : '0;
        glyph_line  = disp_active ? v_line : '0;
        glyph_dot   = disp_active ? h_dot  : '0;
    end
endmodule

// File: rtl/chargrid_timing_chk.sv
// Property checker for chargrid_timing, attached by bind below.
module chargrid_timing_chk
    import cgt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hflb_n,
    input logic              vflb_n,
    input logic [ROW_W-1:0]  grid_row,
    input logic [COL_W-1:0]  grid_col,
    input logic [LINE_W-1:0] glyph_line,
    input logic [DOT_W-1:0]  glyph_dot,
    input logic              disp_active
);
    // R3
    coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_col < COL_W'(GRID_COLS)) && (glyph_dot < DOT_W'(GLYPH_W)) && (grid_row < ROW_W'(GRID_ROWS)));

    // R11
    hfall_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hflb_n && $past(hflb_n)) |=> !disp_active);

    // R5
    vfall_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vflb_n && $past(vflb_n)) |=> !disp_active);

    // R6
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_active && $past(disp_active)) |-> ($stable(glyph_line) && $stable(grid_row)));

    // R3
    dot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_active && $past(disp_active) && $stable(grid_col))
            |-> ((glyph_dot == $past(glyph_dot)) || (glyph_dot == $past(glyph_dot) + DOT_W'(1))));
endmodule

bind chargrid_timing chargrid_timing_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hflb_n      (hflb_n),
    .vflb_n      (vflb_n),
    .grid_row    (grid_row),
    .grid_col    (grid_col),
    .glyph_line  (glyph_line),
    .glyph_dot   (glyph_dot),
    .disp_active (disp_active)
);

// File: tb/sim_chargrid_timing.sv
// Self-checking bench: vector table, then directed reset and flyback tests.
module sim_chargrid_timing;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hflb_n = 1'b1;
    logic       vflb_n = 1'b1;
    logic [7:0] cfg_hstart = '0;
    logic [7:0] cfg_vstart = '0;
    logic [5:0] cfg_row_lines = 6'd16;
    logic       cfg_dbl_height = 1'b0;
    logic       cfg_dbl_width = 1'b0;
    logic [3:0] grid_row;
    logic [4:0] grid_col;
    logic [3:0] glyph_line;
    logic [3:0] glyph_dot;
    logic       disp_active;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    chargrid_timing u0 (
        .clk(clk), .rst_n(rst_n), .hflb_n(hflb_n), .vflb_n(vflb_n),
        .cfg_hstart(cfg_hstart), .cfg_vstart(cfg_vstart), .cfg_row_lines(cfg_row_lines),
        .cfg_dbl_height(cfg_dbl_height), .cfg_dbl_width(cfg_dbl_width),
        .grid_row(grid_row), .grid_col(grid_col), .glyph_line(glyph_line),
        .glyph_dot(glyph_dot), .disp_active(disp_active)
    );

    // Fields: hstart, vstart, row_lines, dbl_h, dbl_w, fall k, offset n,
    //         exp active, row, col, line, dot, requirement number.
    localparam int NV = 18;
    localparam int VEC [NV][13] = '{
        '{ 5, 2, 16, 0, 0,   3,   6, 1, 0,  0,  0, 0,  2},  // R2 first cell
        '{ 5, 2, 16, 0, 0,  20,  43, 1, 1,  3,  1, 7,  6},  // R6
        '{ 0, 0, 20, 0, 0,  46, 124, 1, 2, 12,  4, 3,  3},  // R3
        '{10, 3, 20, 0, 0,  43, 250, 1, 1, 23, 15, 9,  6},  // R6 last line of row
        '{10, 3, 20, 0, 0,  43, 251, 0, 0,  0,  0, 0, 10},  // R10 past right edge
        '{10, 3, 20, 0, 0, 204,  20, 0, 0,  0,  0, 0,  5},  // R5 below grid
        '{10, 3, 20, 0, 0,   3,  20, 0, 0,  0,  0, 0,  5},  // R5 above grid
        '{10, 3, 20, 0, 0,   4,  10, 0, 0,  0,  0, 0,  2},  // R2 one clock early
        '{ 4, 1, 16, 0, 1,   2,  30, 1, 0,  1,  0, 2,  4},  // R4
        '{ 4, 1, 16, 0, 1,   2, 484, 1, 0, 23,  0, 9,  4},  // R4 last dot
        '{ 4, 1, 16, 0, 1,   2, 485, 0, 0,  0,  0, 0,  4},  // R4 window end
        '{ 4, 1, 16, 1, 0,  35,   5, 1, 1,  0,  0, 0,  8},  // R8
        '{ 4, 1, 16, 1, 0,  65,   5, 1, 1,  0, 15, 0,  8},  // R8
        '{ 0, 0, 63, 0, 0,  68,   1, 1, 1,  0,  1, 0,  6},  // R6 odd height
        '{ 0, 0, 63, 0, 0, 630, 240, 1, 9, 23, 15, 9,  5},  // R5 last cell
        '{ 0, 0,  5, 0, 0,  18,   1, 1, 1,  0,  1, 0,  7},  // R7 clamp
        '{ 0, 0, 63, 1, 0, 135,   1, 1, 1,  0,  1, 0,  8},  // R8 height 126
        '{ 0, 0, 63, 0, 0, 631,   1, 0, 0,  0,  0, 0,  5}   // R5 frame end
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Vertical restart pulse, called at a negedge, returns at a negedge.
    task automatic vpulse();
        vflb_n = 1'b0;
        repeat (3) @(negedge clk);
        vflb_n = 1'b1;
        @(negedge clk);
    endtask

    // Short scan line: 2 clocks low, 6 high.
    task automatic short_line();
        hflb_n = 1'b0;
        repeat (2) @(negedge clk);
        hflb_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_all(input string req, input int a, input int r, input int c,
                             input int l, input int d);
        check(req, "active", int'(disp_active), a);
        check(req, "row",    int'(grid_row), r);
        check(req, "col",    int'(grid_col), c);
        check(req, "line",   int'(glyph_line), l);
        check(req, "dot",    int'(glyph_dot), d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 0, 0, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][12], i);
            cfg_hstart     = 8'(VEC[i][0]);
            cfg_vstart     = 8'(VEC[i][1]);
            cfg_row_lines  = 6'(VEC[i][2]);
            cfg_dbl_height = VEC[i][3] != 0;
            cfg_dbl_width  = VEC[i][4] != 0;
            vpulse();
            for (int j = 1; j < VEC[i][5]; j++) short_line();
            hflb_n = 1'b0;
            for (int c = 1; c <= VEC[i][6] + 1; c++) begin
                @(negedge clk);
                if (c == 2) hflb_n = 1'b1;
            end
            check_all(tag, VEC[i][7], VEC[i][8], VEC[i][9], VEC[i][10], VEC[i][11]);
            hflb_n = 1'b1;
            @(negedge clk);
        end

        // R9: a long low flyback pulse counts as one line.
        cfg_hstart = 8'd10; cfg_vstart = 8'd0; cfg_row_lines = 6'd16;
        cfg_dbl_height = 1'b0; cfg_dbl_width = 1'b0;
        vpulse();
        hflb_n = 1'b0;
        repeat (51) @(negedge clk);
        check_all("R9 held", 1, 0, 3, 0, 9);
        repeat (49) @(negedge clk);
        hflb_n = 1'b1;
        repeat (5) @(negedge clk);
        hflb_n = 1'b0;
        repeat (12) @(negedge clk);
        check_all("R9 next line", 1, 0, 0, 1, 0);

        // R11: a fresh horizontal fall inside the window blanks at once.
        hflb_n = 1'b1;
        @(negedge clk);
        check("R11", "active before fall", int'(disp_active), 1);
        hflb_n = 1'b0;
        @(negedge clk);
        check("R11", "active after fall", int'(disp_active), 0);
        hflb_n = 1'b1;
        repeat (2) @(negedge clk);

        finish_run();
    end
endmodule